// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands one multiplier bit per clock cycle. It builds the result in one register that is twice the operand width. When an operand pair is accepted, the upper half of that register is cleared and the lower half takes the multiplier. On every step the block tests the register's least significant bit. If the bit is set, the stored multiplicand is added into the upper half. The whole register then moves one place to the right. The carry out of the add enters at the top, so no sum bit is lost. One adder of operand width does all the work, and the multiplier needs no register of its own.

Operands arrive on a valid/ready handshake. A pair is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` drops for the whole computation, which applies back-pressure to the producer. A request raised while the block is busy is ignored. The result leaves through a one-cycle `out_valid` pulse with no back-pressure. `out_product` then keeps its value until the next pair is accepted, so a consumer may read it late.

Top module: `shiftadd_mul`

## Requirements
- R1: While reset is asserted and right after it, `in_ready` is 1, `out_valid` is 0 and `out_product` is 0.
- R2: A pair is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the cycle after acceptance up to the result cycle.
- R3: `in_valid` raised while `in_ready` is 0 has no effect on the result or on its timing.
- R4: `out_valid` is a single-cycle pulse. It is high in the cycle that follows the W-th rising edge after the accepting edge (W = 32 by default).
- R5: In the result cycle, `out_product` equals the full 2W-bit unsigned product of `in_mcand` and `in_mplier` as they were at acceptance. This includes the all-ones operands, where the carry of the upper-half add is needed.
- R6: Changes on `in_mcand` and `in_mplier` after acceptance do not alter the result.
- R7: After the result cycle, `out_product` stays unchanged until the next accepted pair, whatever the operand inputs do.
- R8: A pair offered during the result cycle is accepted at once. Its result appears W cycles later and is correct.
- R9: `in_ready` is 1 in the result cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle, pair can be accepted |
| in_mcand | input | W | Multiplicand, unsigned |
| in_mplier | input | W | Multiplier, unsigned |
| out_valid | output | 1 | One-cycle pulse: result is present |
| out_product | output | 2W | Product register, final while and after `out_valid` |

## Verification
Two events can share a cycle: the result pulse of one multiplication and the acceptance of the next pair. In that cycle the control returns to idle and raises `in_ready` while the product register still shows the finished value. The bench offers a new pair exactly in the `out_valid` cycle. It checks the first product in that cycle, then checks that the second pair was accepted without a gap, arrived W cycles later and was correct. A second group of tests raises `in_valid` and changes the operands during a multiplication, and checks that neither the result nor its latency moves.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;

endpackage

// File: rtl/shiftadd_mul_adder.sv
module shiftadd_mul_adder #(
  parameter int W      = 32,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W:0]   sum
);

  generate
    if (RIPPLE) begin : g_ripple
      logic [W:0]   carry;
      logic [W-1:0] bits;
      assign carry[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign bits[i]    = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
      end
      assign sum = {carry[W], bits};
    end else begin : g_behav
      assign sum = {1'b0, a} + {1'b0, b};
    end
  endgenerate

endmodule

// File: rtl/shiftadd_mul_ctrl.sv
module shiftadd_mul_ctrl
  import shiftadd_mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic load,
  output logic step,
  output logic done
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mul_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign in_ready = (state_q == ST_IDLE);
  assign load     = in_valid && in_ready;
  assign step     = (state_q == ST_RUN);
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/shiftadd_mul_datapath.sv
module shiftadd_mul_datapath #(
  parameter int W      = 32,
  parameter bit RIPPLE = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic [2*W-1:0] product
);

  localparam int PW = 2 * W;

  logic [W-1:0]  mcand_q;
  logic [PW-1:0] prod_q;
  logic [W-1:0]  addend;
  logic [W:0]    sum;

  assign addend = prod_q[0] ? mcand_q : '0;

  shiftadd_mul_adder #(.W(W), .RIPPLE(RIPPLE)) adder_i (
    .a   (prod_q[PW-1:W]),
    .b   (addend),
    .sum (sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load) begin
      mcand_q <= mcand_in;
      prod_q  <= {{W{1'b0}}, mplier_in};
    end else if (step) begin
      prod_q  <= {sum, prod_q[W-1:1]};
    end
  end

  assign product = prod_q;

endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
  parameter int W      = 32,
  parameter bit RIPPLE = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_mcand,
  input  logic [W-1:0]   in_mplier,
  output logic           out_valid,
  output logic [2*W-1:0] out_product
);

  logic load;
  logic step;

  shiftadd_mul_ctrl #(.W(W)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .load     (load),
    .step     (step),
    .done     (out_valid)
  );

  shiftadd_mul_datapath #(.W(W), .RIPPLE(RIPPLE)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .mcand_in  (in_mcand),
    .mplier_in (in_mplier),
    .product   (out_product)
  );

endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic           out_valid,
  input logic [2*W-1:0] out_product
);

  localparam int CW = $clog2(W) + 2;

  logic [CW-1:0] run_cnt;
  logic          run_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
      run_on  <= 1'b0;
    end else if (in_valid && in_ready) begin
      run_cnt <= '0;
      run_on  <= 1'b1;
    end else if (out_valid) begin
      run_on  <= 1'b0;
    end else if (run_on) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R2: acceptance makes the block busy
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R4: single-cycle result pulse
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R4: result arrives W edges after acceptance
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (run_on && run_cnt == CW'(W)));

  // R7: idle with no request keeps the product
  p_hold_product_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(out_product));

  // R9: ready in the result cycle
  p_ready_on_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

endmodule

bind shiftadd_mul shiftadd_mul_chk #(.W(W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_product (out_product)
);

// File: tb/shiftadd_mul_tb_top.sv
`timescale 1ns/1ps
module shiftadd_mul_tb_top;

  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [W-1:0]   in_mcand = '0;
  logic [W-1:0]   in_mplier = '0;
  logic           out_valid;
  logic [2*W-1:0] out_product;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  shiftadd_mul #(.W(W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_mcand    (in_mcand),
    .in_mplier   (in_mplier),
    .out_valid   (out_valid),
    .out_product (out_product)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // mode 0: plain; 1: request while busy (R3); 2: operands change while busy (R6)
  task automatic do_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                        input int mode, input string tag);
    int k;
    in_valid  = 1'b1;
    in_mcand  = a;
    in_mplier = b;
    chk({"R2 ready before accept ", tag}, 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk({"R2 busy after accept ", tag}, 64'(in_ready), 64'd0);
    k = 0;
    while (!out_valid && k < 200) begin
      @(negedge clk);
      k++;
      if (mode == 1 && k >= 3 && k <= 10) begin
        in_valid  = (k != 10);
        in_mcand  = 32'hDEADBEEF;
        in_mplier = 32'h12345678;
      end
      if (mode == 2 && k == 2) begin
        in_mcand  = ~a;
        in_mplier = ~b;
      end
    end
    chk({"R4 latency ", tag}, 64'(k), 64'(W));
    chk({"R5 product ", tag}, out_product, 64'(a) * 64'(b));
    chk({"R9 ready on result ", tag}, 64'(in_ready), 64'd1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 64'(in_ready), 64'd1);
    chk("R1 valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 64'(in_ready), 64'd1);
    chk("R1 product after reset", out_product, 64'd0);
  endtask

  task automatic t_corners;
    logic [W-1:0] ca [8] = '{32'h0, 32'h0, 32'hFFFFFFFF, 32'h1,
                             32'hFFFFFFFF, 32'h80000000, 32'h80000000, 32'hAAAAAAAA};
    logic [W-1:0] cb [8] = '{32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
                             32'h1, 32'h2, 32'h80000000, 32'h55555555};
    for (int i = 0; i < 8; i++) do_mul(ca[i], cb[i], 0, "corner");
  endtask

  task automatic t_random;
    for (int i = 0; i < 20; i++) do_mul($urandom, $urandom, 0, "random");
  endtask

  task automatic t_busy_request;
    do_mul(32'h0001F00D, 32'hC0FFEE01, 1, "R3 request while busy");
  endtask

  task automatic t_operand_change;
    do_mul(32'hFEDCBA98, 32'h7654321F, 2, "R6 operands change");
  endtask

  task automatic t_hold;
    logic [63:0] held;
    do_mul(32'h00ABCDEF, 32'hF0F0F0F1, 0, "hold");
    held = out_product;
    for (int i = 0; i < 5; i++) begin
      in_mcand  = $urandom;
      in_mplier = $urandom;
      @(negedge clk);
      chk("R4 no second pulse", 64'(out_valid), 64'd0);
      chk("R7 product held", out_product, held);
    end
  endtask

  task automatic t_back_to_back;
    do_mul(32'hFFFFFFFF, 32'h00000003, 0, "R8 first");
    chk("R8 pulse still present", 64'(out_valid), 64'd1);
    do_mul(32'h13579BDF, 32'hFFFFFFFE, 0, "R8 second");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_corners();
    t_random();
    t_busy_request();
    t_operand_change();
    t_hold();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule